// File: doc/BRIEF.md
# Suspend Modulation Clock Throttler

This block lowers a processor core's effective clock rate by pulsing an active-low suspend request. While modulation is on, the pin alternates between two phases. In the asserted phase the pin is low and the core idles. In the deasserted phase the pin is high and the core runs. Each phase length comes from its own 8-bit count, measured in ticks of a fixed 32 us time base. The core therefore delivers full-speed throughput scaled by HIGH / (HIGH + LOW), where HIGH is the run-phase count and LOW is the idle-phase count.

A byte-wide register port holds six registers:
- the run-phase count
- the idle-phase count
- a configuration byte whose bit 0 enables modulation
- a power-management enable byte
- two speedup window lengths, in units of 1 ms

When interrupt or video activity is reported and the matching enable bit is set, the pin is released at once. It stays released for the programmed window after the last activity, and modulation then resumes with a fresh run phase. A prescaler turns the bus clock into the 32 us tick, and a fixed number of those ticks forms one millisecond unit.

The phase controller is a four-state machine:
- `ST_IDLE`: modulation disabled, pin high.
- `ST_RUN_HI`: run phase, pin high.
- `ST_RUN_LO`: idle phase, pin low.
- `ST_BOOST`: speedup hold, pin high.

Its transitions are:
- Any state goes to `ST_IDLE` when the enable bit is clear. This transition has the highest priority.
- Any enabled state goes to `ST_BOOST` while a speedup event or window is active.
- `ST_IDLE` or `ST_BOOST` goes to `ST_RUN_HI` when released. It goes to `ST_RUN_LO` instead when the run count is 0 and the idle count is nonzero.
- `ST_RUN_HI` goes to `ST_RUN_LO` at the end of the run phase, if the idle count is nonzero. Otherwise it reloads the run phase.
- `ST_RUN_LO` goes to `ST_RUN_HI` at the end of the idle phase, if the run count is nonzero. Otherwise it reloads the idle phase.

Top module: `susmod_throttle`

## Requirements
- R1: With modulation enabled and no speedup, the pin repeats a low interval of exactly LOW×TICK_CYC clock cycles and a high interval of exactly HIGH×TICK_CYC cycles. LOW is the idle count (address 0x95) and HIGH is the run count (address 0x94). This holds from the second complete period after the counts are last written.
- R2: One tick is TICK_CYC clock cycles. TICK_CYC defaults to CLK_KHZ×TICK_US/1000, which gives 32 us of the input clock.
- R3: Register addresses are: run count 0x94, idle count 0x95, configuration 0x96, power-management enable 0x80, interrupt window 0x8C, video window 0x8D. A write with reg_we high updates the register at the next clock edge. reg_rdata shows the addressed register in the same cycle. Any other address reads 0, and writes to it change nothing.
- R4: When configuration bit 0 is 0, the pin stays high.
- R5: With modulation enabled, an idle count of 0 keeps the pin high permanently. A run count of 0 with a nonzero idle count keeps the pin low permanently.
- R6: irq_act while enable bit 3 is set, or vid_act while enable bit 4 is set, forces the pin high from the next clock edge. Activity whose enable bit is clear has no effect on the pin.
- R7: After the last qualifying activity, the pin stays high for the window count × MS_TICKS ticks (the first tick may be partial). Modulation then resumes with a run phase followed by an idle phase.
- R8: A count written while a phase is in progress does not change that phase. It takes effect from the next phase that starts after the write.
- R9: After reset all six registers read 0 and the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_act | input | 1 | Interrupt activity indication |
| vid_act | input | 1 | Video activity indication |
| susp_n | output | 1 | Active-low suspend request to the core |

## Verification
Results are due at different times, and the bench samples each at that time:
- Register read data is combinational, so it is checked in the same cycle as the address, after the write edge has passed.
- A qualifying activity pulse releases the pin at the next edge, so the pin is checked at the following falling clock edge.
- Phase lengths are counted in falling-edge samples and compared exactly, using a reduced TICK_CYC. The first period after a count write is discarded, because a write may land on a phase boundary.
- Speedup windows start at an event that is not aligned to a tick. Their high time is therefore checked against a range that allows for one partial tick at the start and the one-cycle release plus the following run phase at the end.

// File: rtl/susmod_pkg.sv
package susmod_pkg;

    // Register addresses
    localparam logic [7:0] ADDR_PMEN   = 8'h80;
    localparam logic [7:0] ADDR_IRQWIN = 8'h8C;
    localparam logic [7:0] ADDR_VIDWIN = 8'h8D;
    localparam logic [7:0] ADDR_HICNT  = 8'h94;
    localparam logic [7:0] ADDR_LOCNT  = 8'h95;
    localparam logic [7:0] ADDR_CFG    = 8'h96;

    // Bit positions
    localparam int CFG_EN_BIT  = 0;
    localparam int PM_IRQ_BIT  = 3;
    localparam int PM_VID_BIT  = 4;
    localparam int NUM_SOURCES = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN_HI,
        ST_RUN_LO,
        ST_BOOST
    } phase_e;

    typedef struct packed {
        logic [7:0] hi_cnt;
        logic [7:0] lo_cnt;
        logic [7:0] cfg;
        logic [7:0] pmen;
        logic [7:0] irq_win;
        logic [7:0] vid_win;
    } regs_t;

endpackage

// File: rtl/susmod_tick.sv
module susmod_tick #(
    parameter int TICK_CYC = 1600
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_CYC > 2) ? $clog2(TICK_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_CYC - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb tick = (div_q == LAST);

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

endmodule

// File: rtl/susmod_regs.sv
module susmod_regs
    import susmod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output regs_t      regs
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (we) begin
            case (addr)
                ADDR_HICNT:  regs.hi_cnt  <= wdata;
                ADDR_LOCNT:  regs.lo_cnt  <= wdata;
                ADDR_CFG:    regs.cfg     <= wdata;
                ADDR_PMEN:   regs.pmen    <= wdata;
                ADDR_IRQWIN: regs.irq_win <= wdata;
                ADDR_VIDWIN: regs.vid_win <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            ADDR_HICNT:  rdata = regs.hi_cnt;
            ADDR_LOCNT:  rdata = regs.lo_cnt;
            ADDR_CFG:    rdata = regs.cfg;
            ADDR_PMEN:   rdata = regs.pmen;
            ADDR_IRQWIN: rdata = regs.irq_win;
            ADDR_VIDWIN: rdata = regs.vid_win;
            default:     rdata = 8'h00;
        endcase
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(regs)); // R3

endmodule

// File: rtl/susmod_boost.sv
module susmod_boost #(
    parameter int MS_TICKS = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       trigger,
    input  logic [7:0] win,
    output logic       busy
);
    localparam int TW = 8 + $clog2(MS_TICKS + 1);

    logic [TW-1:0] left_q;
    logic [TW-1:0] load_val;

    always_comb load_val = TW'(win) * TW'(MS_TICKS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trigger) begin
            left_q <= load_val;
        end else if (tick && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    always_comb busy = (left_q != '0);

    AST_WINDOW_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!trigger && left_q != '0) |=> (left_q <= $past(left_q))); // R7

endmodule

// File: rtl/susmod_fsm.sv
module susmod_fsm
    import susmod_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic       hold,
    input  logic [7:0] hi_len,
    input  logic [7:0] lo_len,
    output logic       susp_n
);
    phase_e     state_q, state_d;
    logic [7:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (hold) begin
            state_d = ST_BOOST;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_BOOST: begin
                    if (hi_len == 8'd0 && lo_len != 8'd0) begin
                        state_d = ST_RUN_LO;
                        cnt_d   = lo_len;
                    end else begin
                        state_d = ST_RUN_HI;
                        cnt_d   = hi_len;
                    end
                end
                ST_RUN_HI: begin
                    if (cnt_q == 8'd0 || (tick && cnt_q == 8'd1)) begin
                        if (lo_len != 8'd0) begin
                            state_d = ST_RUN_LO;
                            cnt_d   = lo_len;
                        end else begin
                            cnt_d   = hi_len;
                        end
                    end else if (tick) begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                ST_RUN_LO: begin
                    if (tick && cnt_q <= 8'd1) begin
                        if (hi_len != 8'd0) begin
                            state_d = ST_RUN_HI;
                            cnt_d   = hi_len;
                        end else if (lo_len != 8'd0) begin
                            cnt_d   = lo_len;
                        end else begin
                            state_d = ST_RUN_HI;
                            cnt_d   = 8'd0;
                        end
                    end else if (tick) begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb susp_n = (state_q != ST_RUN_LO);

    AST_IDLE_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> susp_n); // R4
    AST_HOLD_PIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> susp_n); // R6
    AST_LO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN_LO) |-> (cnt_q != 8'd0)); // R5
    AST_PHASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !hold && state_q == ST_RUN_LO && !tick)
            |=> ($stable(cnt_q) && state_q == ST_RUN_LO)); // R8

endmodule

// File: rtl/susmod_throttle.sv
module susmod_throttle
    import susmod_pkg::*;
#(
    parameter int CLK_KHZ  = 50000,
    parameter int TICK_US  = 32,
    parameter int TICK_CYC = CLK_KHZ * TICK_US / 1000,
    parameter int MS_TICKS = 1000 / TICK_US
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       irq_act,
    input  logic       vid_act,
    output logic       susp_n
);
    regs_t                  regs;
    logic                   tick;
    logic [NUM_SOURCES-1:0] trig;
    logic [NUM_SOURCES-1:0] busy;
    logic [7:0]             win [NUM_SOURCES];
    logic                   hold;
    logic                   unused_cfg_bits;

    susmod_tick #(.TICK_CYC(TICK_CYC)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    susmod_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .regs  (regs)
    );

    always_comb begin
        trig[0] = irq_act & regs.pmen[PM_IRQ_BIT];
        trig[1] = vid_act & regs.pmen[PM_VID_BIT];
        win[0]  = regs.irq_win;
        win[1]  = regs.vid_win;
    end

    for (genvar g = 0; g < NUM_SOURCES; g++) begin : g_boost
        susmod_boost #(.MS_TICKS(MS_TICKS)) u_boost (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .trigger (trig[g]),
            .win     (win[g]),
            .busy    (busy[g])
        );
    end

    always_comb hold = (|trig) | (|busy);
    always_comb unused_cfg_bits = ^{regs.cfg[7:1], regs.pmen[7:5], regs.pmen[2:0]};

    susmod_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (regs.cfg[CFG_EN_BIT]),
        .hold   (hold),
        .hi_len (regs.hi_cnt),
        .lo_len (regs.lo_cnt),
        .susp_n (susp_n)
    );

endmodule

// File: tb/susmod_throttle_tb.sv
module susmod_throttle_tb;
    localparam int TC = 4;
    localparam int MS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_act = 1'b0;
    logic       vid_act = 1'b0;
    logic       susp_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    susmod_throttle #(.TICK_CYC(TC), .MS_TICKS(MS)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_act(irq_act),
        .vid_act(vid_act), .susp_n(susp_n)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic int exp_len(input int cnt);
        return cnt * TC;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == e, req, int'(reg_rdata), int'(e));
    endtask

    task automatic wait_level(input logic lvl);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (susp_n == lvl) break;
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (susp_n == lvl) n = n + 1;
            else break;
        end
    endtask

    task automatic measure(output int lo, output int hi);
        wait_level(1'b1);
        wait_level(1'b0);
        run_len(1'b0, lo);
        run_len(1'b1, hi);
    endtask

    task automatic count_low(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (susp_n == 1'b0) lows = lows + 1;
        end
    endtask

    initial begin
        int lo, hi, n, n2, lows;
        logic [7:0] a, b;
        void'($urandom(32'd4711));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk(susp_n == 1'b1, "R9", int'(susp_n), 1);
        rd_chk(8'h94, 8'h00, "R9");
        rd_chk(8'h95, 8'h00, "R9");
        rd_chk(8'h96, 8'h00, "R9");
        rd_chk(8'h80, 8'h00, "R9");
        rd_chk(8'h8C, 8'h00, "R9");
        rd_chk(8'h8D, 8'h00, "R9");

        // R3: register map and unused addresses
        wr(8'h94, 8'h11); wr(8'h95, 8'h22); wr(8'h80, 8'h44);
        wr(8'h8C, 8'h55); wr(8'h8D, 8'h66); wr(8'h90, 8'hFF);
        rd_chk(8'h94, 8'h11, "R3");
        rd_chk(8'h95, 8'h22, "R3");
        rd_chk(8'h80, 8'h44, "R3");
        rd_chk(8'h8C, 8'h55, "R3");
        rd_chk(8'h8D, 8'h66, "R3");
        rd_chk(8'h90, 8'h00, "R3");
        wr(8'h80, 8'h00);

        // R4: disabled modulation keeps the pin high
        wr(8'h94, 8'd3); wr(8'h95, 8'd3); wr(8'h96, 8'h00);
        count_low(120, lows);
        chk(lows == 0, "R4", lows, 0);

        // R2, R1: minimum phases of one tick each
        wr(8'h96, 8'h01);
        wr(8'h94, 8'd1); wr(8'h95, 8'd1);
        measure(lo, hi);
        measure(lo, hi);
        chk(lo == exp_len(1), "R2 low", lo, exp_len(1));
        chk(hi == exp_len(1), "R2 high", hi, exp_len(1));

        // R1: random counts
        for (int k = 0; k < 6; k++) begin
            a = 8'($urandom_range(1, 10));
            b = 8'($urandom_range(1, 10));
            wr(8'h94, a); wr(8'h95, b);
            measure(lo, hi);
            measure(lo, hi);
            chk(lo == exp_len(int'(b)), "R1 low", lo, exp_len(int'(b)));
            chk(hi == exp_len(int'(a)), "R1 high", hi, exp_len(int'(a)));
        end

        // R8: count change mid-phase applies at the next phase
        wr(8'h94, 8'd2); wr(8'h95, 8'd6);
        measure(lo, hi);
        wait_level(1'b1);
        wait_level(1'b0);
        reg_we = 1'b1; reg_addr = 8'h95; reg_wdata = 8'd3;
        @(negedge clk);
        reg_we = 1'b0;
        run_len(1'b0, n);
        chk(n + 1 == exp_len(6), "R8 current", n + 1, exp_len(6));
        run_len(1'b1, hi);
        chk(hi == exp_len(2), "R8 high", hi, exp_len(2));
        run_len(1'b0, lo);
        chk(lo == exp_len(3), "R8 next", lo, exp_len(3));

        // R5: zero idle count never asserts; zero run count stays asserted
        wr(8'h95, 8'd0); wr(8'h94, 8'd3);
        repeat (10) @(negedge clk);
        count_low(150, lows);
        chk(lows == 0, "R5 lo=0", lows, 0);
        wr(8'h95, 8'd3); wr(8'h94, 8'd0);
        repeat (20) @(negedge clk);
        count_low(150, lows);
        chk(lows == 150, "R5 hi=0", lows, 150);

        // R6, R7: interrupt speedup
        wr(8'h94, 8'd1); wr(8'h95, 8'd5);
        wr(8'h80, 8'h08); wr(8'h8C, 8'd2);
        measure(lo, hi);
        wait_level(1'b1);
        wait_level(1'b0);
        @(negedge clk); @(negedge clk);
        irq_act = 1'b1;
        @(negedge clk);
        irq_act = 1'b0;
        chk(susp_n == 1'b1, "R6 irq", int'(susp_n), 1);
        run_len(1'b1, hi);
        chk(hi >= 22 && hi <= 30, "R7 irq window", hi, 26);
        run_len(1'b0, lo);
        chk(lo == exp_len(5), "R7 resume", lo, exp_len(5));

        // R6: disabled source ignored, enabled video source honoured
        wr(8'h80, 8'h10); wr(8'h8D, 8'd1);
        wait_level(1'b1);
        wait_level(1'b0);
        @(negedge clk);
        irq_act = 1'b1;
        @(negedge clk);
        irq_act = 1'b0;
        run_len(1'b0, n2);
        chk(n2 + 2 == exp_len(5), "R6 ignored", n2 + 2, exp_len(5));
        wait_level(1'b0);
        @(negedge clk);
        vid_act = 1'b1;
        @(negedge clk);
        vid_act = 1'b0;
        chk(susp_n == 1'b1, "R6 vid", int'(susp_n), 1);
        run_len(1'b1, hi);
        chk(hi >= 10 && hi <= 18, "R7 vid window", hi, 14);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule